// File: doc/BRIEF.md
# Load-Bypass Memory Request Orderer

This block sits on the access side of a decoupled processor. It places memory requests in order before they go to memory. Load addresses and store addresses arrive on separate enqueue ports. Each kind waits in its own first-in first-out queue. Store data produced by the execute side arrives in a third queue and pairs with the store addresses in arrival order.

Each cycle in which memory is ready, the block sends at most one request. The head load may go ahead of older stores that are still pending, as long as none of them targets the same full word address. A store goes out only once its paired data word is present. When both heads can go, the load goes first. Loads never pass other loads, and stores never pass other stores.

Every queue is `DEPTH` entries deep, and `DEPTH` must be a power of two. A full queue raises its full flag and refuses further pushes.

Top module: `ldst_order_q`

## Requirements
- R1: After reset all three queues are empty: `mem_valid` is 0 even with `mem_ready` high, and `ld_full`, `st_full` and `sd_full` are 0.
- R2: Loads reach memory in the order their addresses were pushed.
- R3: Stores reach memory in the order their addresses were pushed.
- R4: The head load issues ahead of older pending stores when none of those stores has an address equal to the load address.
- R5: A load whose address equals that of an older pending store does not issue until that store has issued. It issues in the next cycle in which it is at the head and memory is ready.
- R6: A store issues only while at least one store-data word is queued. The k-th store pushed carries the k-th data word pushed, on `mem_data`. For a load, `mem_data` is 0.
- R7: When the head load and the head store can both issue, the load issues, even if the store is older.
- R8: `mem_valid` is high only in a cycle where `mem_ready` is high, and it carries one request per cycle. `mem_is_store` is 1 for a store and 0 for a load.
- R9: A queue holding `DEPTH` entries raises its full flag. A push into a full queue is dropped, and that entry never reaches memory.
- R10: A load and a store pushed in the same cycle count as load-older. Equal addresses then do not block the load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ld_push | input | 1 | Enqueue a load address |
| ld_addr | input | AW | Load word address |
| ld_full | output | 1 | Load queue full; a push is refused |
| st_push | input | 1 | Enqueue a store address |
| st_addr | input | AW | Store word address |
| st_full | output | 1 | Store address queue full |
| sd_push | input | 1 | Enqueue a store data word |
| sd_data | input | DW | Store data word |
| sd_full | output | 1 | Store data queue full |
| mem_ready | input | 1 | Memory accepts a request this cycle |
| mem_valid | output | 1 | A request issues this cycle |
| mem_is_store | output | 1 | 1 = store, 0 = load |
| mem_addr | output | AW | Request address |
| mem_data | output | DW | Store data (0 for loads) |

## Verification
The two functions that can fall in the same cycle are load issue and store issue: both heads can be eligible at once. The bench sets this up in two ways. In one, a store with its data ready waits behind a younger load at a different address. In the other, a load and a store to the same address are pushed in the same cycle together with the data. It then judges by the issue order and by the type bit seen on `mem_valid` cycles: the load must come first and the store in the following ready cycle. A blocked load must let its matching older store drain before it moves.

// File: rtl/ldst_order_q.sv
module ldst_order_q #(
  parameter int AW    = 32,
  parameter int DW    = 32,
  parameter int DEPTH = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ld_push,
  input  logic [AW-1:0] ld_addr,
  output logic          ld_full,
  input  logic          st_push,
  input  logic [AW-1:0] st_addr,
  output logic          st_full,
  input  logic          sd_push,
  input  logic [DW-1:0] sd_data,
  output logic          sd_full,
  input  logic          mem_ready,
  output logic          mem_valid,
  output logic          mem_is_store,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_data
);
  localparam int PW = $clog2(DEPTH);
  localparam int CW = PW + 1;

  logic [AW-1:0] lq_a [DEPTH];
  logic [CW-1:0] lq_snap [DEPTH];
  logic [AW-1:0] sq_a [DEPTH];
  logic [DW-1:0] dq [DEPTH];
  logic [CW-1:0] lrd, lwr, srd, swr, drd, dwr;

  logic [CW-1:0] lcnt, scnt, dcnt, n_older, p;
  logic          hit, ld_ok, st_ok, ld_go, st_go;

  assign lcnt    = lwr - lrd;
  assign scnt    = swr - srd;
  assign dcnt    = dwr - drd;
  assign ld_full = lcnt == CW'(DEPTH);
  assign st_full = scnt == CW'(DEPTH);
  assign sd_full = dcnt == CW'(DEPTH);

  // number of pending stores older than the head load
  assign n_older = lq_snap[lrd[PW-1:0]] - srd;

  always_comb begin
    hit = 1'b0;
    p   = '0;
    for (int i = 0; i < DEPTH; i++) begin
      p = srd + CW'(i);
      if (CW'(i) < n_older && sq_a[p[PW-1:0]] == lq_a[lrd[PW-1:0]])
        hit = 1'b1;
    end
  end

  assign ld_ok = (lcnt != '0) && !hit;
  assign st_ok = (scnt != '0) && (dcnt != '0);
  assign ld_go = mem_ready && ld_ok;
  assign st_go = mem_ready && st_ok && !ld_ok;

  assign mem_valid    = ld_go || st_go;
  assign mem_is_store = st_go;
  assign mem_addr     = st_go ? sq_a[srd[PW-1:0]] : lq_a[lrd[PW-1:0]];
  assign mem_data     = st_go ? dq[drd[PW-1:0]] : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lrd <= '0; lwr <= '0;
      srd <= '0; swr <= '0;
      drd <= '0; dwr <= '0;
    end else begin
      if (ld_push && !ld_full) lwr <= lwr + 1'b1;
      if (st_push && !st_full) swr <= swr + 1'b1;
      if (sd_push && !sd_full) dwr <= dwr + 1'b1;
      if (ld_go) lrd <= lrd + 1'b1;
      if (st_go) begin
        srd <= srd + 1'b1;
        drd <= drd + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (ld_push && !ld_full) begin
      lq_a[lwr[PW-1:0]]    <= ld_addr;
      lq_snap[lwr[PW-1:0]] <= swr;
    end
    if (st_push && !st_full) sq_a[swr[PW-1:0]] <= st_addr;
    if (sd_push && !sd_full) dq[dwr[PW-1:0]]   <= sd_data;
  end

  assert_issue_ready_R8: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid |-> mem_ready);

  assert_store_data_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && mem_is_store) |-> (dcnt != '0));

  assert_full_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_full && !(mem_valid && !mem_is_store)) |=> ld_full);

  assert_sd_full_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (sd_full && !(mem_valid && mem_is_store)) |=> sd_full);

  // stores never overtake a pending load (R10 snapshot ordering)
  assert_snap_bound_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (lcnt != '0) |-> (n_older <= scnt));
endmodule

// File: tb/ldst_order_q_tb.sv
`timescale 1ns/1ps
module ldst_order_q_tb;
  logic clk = 1'b0, rst_n = 1'b0;
  logic ld_push = 0, st_push = 0, sd_push = 0, mem_ready = 0;
  logic [31:0] ld_addr = 0, st_addr = 0, sd_data = 0;
  logic ld_full, st_full, sd_full, mem_valid, mem_is_store;
  logic [31:0] mem_addr, mem_data;
  int checks = 0, failures = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  ldst_order_q u_dut (
    .clk(clk), .rst_n(rst_n),
    .ld_push(ld_push), .ld_addr(ld_addr), .ld_full(ld_full),
    .st_push(st_push), .st_addr(st_addr), .st_full(st_full),
    .sd_push(sd_push), .sd_data(sd_data), .sd_full(sd_full),
    .mem_ready(mem_ready), .mem_valid(mem_valid), .mem_is_store(mem_is_store),
    .mem_addr(mem_addr), .mem_data(mem_data)
  );

  typedef struct packed {
    logic ldv; logic [7:0] lda;
    logic stv; logic [7:0] sta;
    logic sdv; logic [7:0] sdd;
    logic rdy;
    logic ev; logic est; logic [7:0] ea; logic [7:0] ed;
    logic [7:0] req;
  } vec_t;

  // rows: drive, then compare outputs before the next edge commits
  localparam vec_t TBL [26] = '{
    '{1'b0,8'h00,1'b1,8'h10,1'b0,8'h00,1'b1, 1'b0,1'b0,8'h00,8'h00, 8'd6},
    '{1'b1,8'h20,1'b0,8'h00,1'b0,8'h00,1'b1, 1'b0,1'b0,8'h00,8'h00, 8'd6},
    '{1'b1,8'h10,1'b0,8'h00,1'b0,8'h00,1'b1, 1'b1,1'b0,8'h20,8'h00, 8'd4},  // R4
    '{1'b0,8'h00,1'b0,8'h00,1'b0,8'h00,1'b1, 1'b0,1'b0,8'h00,8'h00, 8'd5},  // R5 blocked
    '{1'b0,8'h00,1'b0,8'h00,1'b1,8'hAA,1'b1, 1'b0,1'b0,8'h00,8'h00, 8'd5},
    '{1'b0,8'h00,1'b0,8'h00,1'b0,8'h00,1'b1, 1'b1,1'b1,8'h10,8'hAA, 8'd6},  // R6
    '{1'b0,8'h00,1'b0,8'h00,1'b0,8'h00,1'b1, 1'b1,1'b0,8'h10,8'h00, 8'd5},
    '{1'b1,8'h40,1'b1,8'h40,1'b1,8'hBB,1'b1, 1'b0,1'b0,8'h00,8'h00, 8'd8},
    '{1'b0,8'h00,1'b0,8'h00,1'b0,8'h00,1'b0, 1'b0,1'b0,8'h00,8'h00, 8'd8},  // R8
    '{1'b0,8'h00,1'b0,8'h00,1'b0,8'h00,1'b1, 1'b1,1'b0,8'h40,8'h00, 8'd10}, // R10
    '{1'b0,8'h00,1'b0,8'h00,1'b0,8'h00,1'b1, 1'b1,1'b1,8'h40,8'hBB, 8'd3},
    '{1'b1,8'h01,1'b0,8'h00,1'b0,8'h00,1'b0, 1'b0,1'b0,8'h00,8'h00, 8'd8},
    '{1'b1,8'h02,1'b0,8'h00,1'b0,8'h00,1'b0, 1'b0,1'b0,8'h00,8'h00, 8'd8},
    '{1'b1,8'h03,1'b0,8'h00,1'b0,8'h00,1'b0, 1'b0,1'b0,8'h00,8'h00, 8'd8},
    '{1'b0,8'h00,1'b0,8'h00,1'b0,8'h00,1'b1, 1'b1,1'b0,8'h01,8'h00, 8'd2},  // R2
    '{1'b0,8'h00,1'b0,8'h00,1'b0,8'h00,1'b1, 1'b1,1'b0,8'h02,8'h00, 8'd2},
    '{1'b0,8'h00,1'b0,8'h00,1'b0,8'h00,1'b1, 1'b1,1'b0,8'h03,8'h00, 8'd2},
    '{1'b0,8'h00,1'b1,8'h05,1'b1,8'h11,1'b0, 1'b0,1'b0,8'h00,8'h00, 8'd8},
    '{1'b0,8'h00,1'b1,8'h06,1'b1,8'h22,1'b0, 1'b0,1'b0,8'h00,8'h00, 8'd8},
    '{1'b0,8'h00,1'b0,8'h00,1'b0,8'h00,1'b1, 1'b1,1'b1,8'h05,8'h11, 8'd3},  // R3
    '{1'b0,8'h00,1'b0,8'h00,1'b0,8'h00,1'b1, 1'b1,1'b1,8'h06,8'h22, 8'd3},
    '{1'b0,8'h00,1'b1,8'h07,1'b1,8'h33,1'b0, 1'b0,1'b0,8'h00,8'h00, 8'd8},
    '{1'b1,8'h08,1'b0,8'h00,1'b0,8'h00,1'b0, 1'b0,1'b0,8'h00,8'h00, 8'd8},
    '{1'b0,8'h00,1'b0,8'h00,1'b0,8'h00,1'b1, 1'b1,1'b0,8'h08,8'h00, 8'd7},  // R7
    '{1'b0,8'h00,1'b0,8'h00,1'b0,8'h00,1'b1, 1'b1,1'b1,8'h07,8'h33, 8'd7},
    '{1'b0,8'h00,1'b0,8'h00,1'b0,8'h00,1'b1, 1'b0,1'b0,8'h00,8'h00, 8'd8}
  };

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle_inputs();
    ld_push = 0; st_push = 0; sd_push = 0; mem_ready = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    mem_ready = 1;
    #1;
    check("R1 reset no issue", {63'd0, mem_valid}, 64'd0);
    rst_n = 1;
    @(negedge clk); #1;
    check("R1 idle after reset", {60'd0, mem_valid, ld_full, st_full, sd_full}, 64'd0);

    for (int r = 0; r < 26; r++) begin
      @(negedge clk);
      ld_push = TBL[r].ldv; ld_addr = {24'd0, TBL[r].lda};
      st_push = TBL[r].stv; st_addr = {24'd0, TBL[r].sta};
      sd_push = TBL[r].sdv; sd_data = {24'd0, TBL[r].sdd};
      mem_ready = TBL[r].rdy;
      #1;
      if (TBL[r].ev)
        check($sformatf("R%0d row %0d", TBL[r].req, r),
              {46'd0, mem_valid, mem_is_store, mem_addr[7:0], mem_data[7:0]},
              {46'd0, 1'b1, TBL[r].est, TBL[r].ea, TBL[r].ed});
      else
        check($sformatf("R%0d row %0d idle", TBL[r].req, r), {63'd0, mem_valid}, 64'd0);
    end

    // R9: fill store address and data queues, overflow push is dropped
    for (int i = 0; i < 8; i++) begin
      @(negedge clk); idle_inputs();
      st_push = 1; st_addr = 32'h80 + i;
    end
    @(negedge clk); idle_inputs(); #1;
    check("R9 st_full", {63'd0, st_full}, 64'd1);
    st_push = 1; st_addr = 32'h99;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk); idle_inputs();
      sd_push = 1; sd_data = 32'hC0 + i;
    end
    @(negedge clk); idle_inputs(); #1;
    check("R9 sd_full", {63'd0, sd_full}, 64'd1);
    for (int i = 0; i < 8; i++) begin
      @(negedge clk); idle_inputs(); mem_ready = 1; #1;
      check($sformatf("R9 R3 drain store %0d", i),
            {mem_valid, mem_is_store, mem_addr, mem_data},
            {1'b1, 1'b1, 32'h80 + i, 32'hC0 + i});
    end
    @(negedge clk); idle_inputs(); mem_ready = 1; #1;
    check("R9 refused store absent", {63'd0, mem_valid}, 64'd0);

    // R9: fill load queue, overflow push is dropped
    for (int i = 0; i < 8; i++) begin
      @(negedge clk); idle_inputs();
      ld_push = 1; ld_addr = 32'h200 + i;
    end
    @(negedge clk); idle_inputs(); #1;
    check("R9 ld_full", {63'd0, ld_full}, 64'd1);
    ld_push = 1; ld_addr = 32'h2FF;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk); idle_inputs(); mem_ready = 1; #1;
      check($sformatf("R9 R2 drain load %0d", i),
            {mem_valid, mem_is_store, mem_addr, mem_data},
            {1'b1, 1'b0, 32'h200 + i, 32'h0});
    end
    @(negedge clk); idle_inputs(); mem_ready = 1; #1;
    check("R9 refused load absent", {63'd0, mem_valid}, 64'd0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule